// File: doc/BRIEF.md
# Neighbor-Shared Dual-Port Lookup RAM with Mailbox Events

This block is a 512-word, 32-bit lookup memory placed between two neighbouring processing cores. Each core has its own port, with its own address, write enable, write data and read data, and both ports may read or write in the same clock cycle. The block works for a ring, where each core shares one memory with the next and the last wraps to the first, and also for fixed pairs. That choice lives in the wiring around the block, not inside it.

The two highest words of the memory are mailbox words. When one side writes either of them, the opposite side sees a single-cycle event pulse on the clock edge that stores the write, so the partner can react without polling. Reads are read-first, so one port can feed a streaming reader while the other port rewrites the same table. The reader always gets either the complete old word or the complete new word.

Top module: `neighbor_lut`

## Requirements
- R1: A word written through either port can be read back through the other port at the same address.
- R2: Read data appears on the port's read output after the first rising clock edge at which its address is presented (one cycle of latency), and a new address every cycle gives a new word every cycle.
- R3: A read of an address that the other port writes in the same cycle returns the word stored before that write. The new word is returned from the next cycle on.
- R4: A write by port B to address 0x1FE sets bit 0 of `a_event`, and a write by port B to address 0x1FF sets bit 1 of `a_event`. Each bit is high for exactly the one cycle after the write edge.
- R5: A write by port A to 0x1FE or 0x1FF sets bit 0 or bit 1 of `b_event` in the same way. A mailbox write never raises an event on the writer's own side.
- R6: Writes to any address below 0x1FE, and reads of any address, raise no event.
- R7: When both ports write the same address in one cycle, port A's data is stored and `wr_clash` is high for the one cycle after that edge.
- R8: While synchronous reset is held, and right after it, `a_event`, `b_event`, `wr_clash`, `a_rdata` and `b_rdata` are all zero. Memory contents are not cleared.
- R9: Simultaneous writes to different addresses both take effect and do not raise `wr_clash`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_addr | input | 9 | Port A word address |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data, one cycle after address |
| a_event | output | 2 | Mailbox pulses toward side A (bit 0: word 0x1FE, bit 1: word 0x1FF) |
| b_addr | input | 9 | Port B word address |
| b_we | input | 1 | Port B write enable |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data, one cycle after address |
| b_event | output | 2 | Mailbox pulses toward side B (bit 0: word 0x1FE, bit 1: word 0x1FF) |
| wr_clash | output | 1 | Pulse after both ports wrote the same address |

## Verification
The assertions check, on every cycle, that every event bit follows a write by the opposite port to the matching mailbox word, that at most one event bit per side is set, that `wr_clash` only follows a same-address double write, and that all pulse outputs are quiet right after reset. What ends up in storage can only be shown by the bench's scenarios. That covers cross-port readback, read-first data while the other side writes, port A winning a collision, and independent writes to distinct addresses landing together. The bench's exact cycle checks also show that each event lasts a single cycle and lands on the opposite side only.

// File: rtl/lut_pkg.sv
package lut_pkg;

    localparam int LUT_ADDR_W = 9;
    localparam int LUT_DATA_W = 32;
    localparam int LUT_DEPTH  = 1 << LUT_ADDR_W;
    localparam int MBOX_WORDS = 2;
    localparam logic [LUT_ADDR_W-1:0] MBOX_BASE = LUT_ADDR_W'(LUT_DEPTH - MBOX_WORDS);

    typedef struct packed {
        logic                  we;
        logic [LUT_ADDR_W-1:0] addr;
        logic [LUT_DATA_W-1:0] wdata;
    } lut_req_t;

    typedef logic [MBOX_WORDS-1:0] mbox_evt_t;

    function automatic logic is_mbox(input logic [LUT_ADDR_W-1:0] addr);
        return addr >= MBOX_BASE;
    endfunction

    function automatic mbox_evt_t mbox_decode(input lut_req_t req);
        mbox_evt_t sel;
        sel = '0;
        for (int i = 0; i < MBOX_WORDS; i++) begin
            if (req.we && req.addr == MBOX_BASE + LUT_ADDR_W'(i)) sel[i] = 1'b1;
        end
        return sel;
    endfunction

endpackage

// File: rtl/nbr_lut_store.sv
module nbr_lut_store
    import lut_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  lut_req_t              req_a,
    input  lut_req_t              req_b,
    output logic [LUT_DATA_W-1:0] rdata_a,
    output logic [LUT_DATA_W-1:0] rdata_b
);

    logic [LUT_DATA_W-1:0] words [LUT_DEPTH];

    // Storage: B is applied first so A overrides it on a shared address.
    always_ff @(posedge clk) begin
        if (req_b.we) words[req_b.addr] <= req_b.wdata;
        if (req_a.we) words[req_a.addr] <= req_a.wdata;
    end

    // Read-first output registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_a <= '0;
            rdata_b <= '0;
        end else begin
            rdata_a <= words[req_a.addr];
            rdata_b <= words[req_b.addr];
        end
    end

endmodule

// File: rtl/nbr_lut_mbox.sv
module nbr_lut_mbox
    import lut_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lut_req_t  writer_req,
    output mbox_evt_t evt_o
);

    always_ff @(posedge clk) begin
        if (rst) evt_o <= '0;
        else     evt_o <= mbox_decode(writer_req);
    end

    AST_EVT_FROM_MBOX_WRITE: assert property (@(posedge clk) disable iff (rst)
        (evt_o != '0) |-> $past(writer_req.we && is_mbox(writer_req.addr))); // R6

    AST_EVT_SINGLE_WORD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_o)); // R4

    AST_EVT_HIGH_WORD: assert property (@(posedge clk) disable iff (rst)
        evt_o[MBOX_WORDS-1] |-> $past(writer_req.addr) == LUT_ADDR_W'(LUT_DEPTH - 1)); // R5

endmodule

// File: rtl/nbr_lut_clash.sv
module nbr_lut_clash
    import lut_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lut_req_t req_a,
    input  lut_req_t req_b,
    output logic     clash_o
);

    logic same_word;
    assign same_word = req_a.we && req_b.we && (req_a.addr == req_b.addr);

    always_ff @(posedge clk) begin
        if (rst) clash_o <= 1'b0;
        else     clash_o <= same_word;
    end

    AST_CLASH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        clash_o |-> $past(req_a.we && req_b.we && req_a.addr == req_b.addr)); // R7

    AST_CLASH_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (req_a.we && req_b.we && req_a.addr != req_b.addr) |=> !clash_o); // R9

endmodule

// File: rtl/neighbor_lut.sv
module neighbor_lut
    import lut_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LUT_ADDR_W-1:0] a_addr,
    input  logic                  a_we,
    input  logic [LUT_DATA_W-1:0] a_wdata,
    output logic [LUT_DATA_W-1:0] a_rdata,
    output logic [MBOX_WORDS-1:0] a_event,
    input  logic [LUT_ADDR_W-1:0] b_addr,
    input  logic                  b_we,
    input  logic [LUT_DATA_W-1:0] b_wdata,
    output logic [LUT_DATA_W-1:0] b_rdata,
    output logic [MBOX_WORDS-1:0] b_event,
    output logic                  wr_clash
);

    localparam int SIDES = 2;

    lut_req_t  req [SIDES];
    mbox_evt_t evt [SIDES];

    assign req[0] = '{we: a_we, addr: a_addr, wdata: a_wdata};
    assign req[1] = '{we: b_we, addr: b_addr, wdata: b_wdata};

    nbr_lut_store store_i (
        .clk     (clk),
        .rst     (rst),
        .req_a   (req[0]),
        .req_b   (req[1]),
        .rdata_a (a_rdata),
        .rdata_b (b_rdata)
    );

    // Each side's event is driven by the opposite side's writes.
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        nbr_lut_mbox mbox_i (
            .clk        (clk),
            .rst        (rst),
            .writer_req (req[SIDES-1-s]),
            .evt_o      (evt[s])
        );
    end

    assign a_event = evt[0];
    assign b_event = evt[1];

    nbr_lut_clash clash_i (
        .clk     (clk),
        .rst     (rst),
        .req_a   (req[0]),
        .req_b   (req[1]),
        .clash_o (wr_clash)
    );

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_event == '0 && b_event == '0 && !wr_clash
                        && a_rdata == '0 && b_rdata == '0)); // R8

    AST_A_EVENT_FROM_B: assert property (@(posedge clk) disable iff (rst)
        (a_event != '0) |-> $past(b_we)); // R4

    AST_B_EVENT_FROM_A: assert property (@(posedge clk) disable iff (rst)
        (b_event != '0) |-> $past(a_we)); // R5

endmodule

// File: tb/neighbor_lut_tb_top.sv
module neighbor_lut_tb_top;
    import lut_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst;
    logic [LUT_ADDR_W-1:0] a_addr, b_addr;
    logic                  a_we, b_we;
    logic [LUT_DATA_W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic [1:0]            a_event, b_event;
    logic                  wr_clash;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    neighbor_lut dut_i (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_event(a_event),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_event(b_event),
        .wr_clash(wr_clash)
    );

    typedef struct {
        bit           chk_a;
        logic [31:0]  exp_a;
        bit           chk_b;
        logic [31:0]  exp_b;
        logic [1:0]   exp_aevt;
        logic [1:0]   exp_bevt;
        logic         exp_clash;
        string        req;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus at the falling edge and queues its expected result.
    task automatic cyc(input bit awe, input int aad, input logic [31:0] awd,
                       input bit bwe, input int bad, input logic [31:0] bwd,
                       input bit ca, input logic [31:0] ea, input bit cb, input logic [31:0] eb,
                       input logic [1:0] aev, input logic [1:0] bev, input logic clash, input string req);
        exp_t e;
        @(negedge clk);
        a_we = awe; a_addr = 9'(aad); a_wdata = awd;
        b_we = bwe; b_addr = 9'(bad); b_wdata = bwd;
        e.chk_a = ca; e.exp_a = ea; e.chk_b = cb; e.exp_b = eb;
        e.exp_aevt = aev; e.exp_bevt = bev; e.exp_clash = clash; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compares outputs shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.chk_a) check(e.req, "a_rdata", a_rdata, e.exp_a);
            if (e.chk_b) check(e.req, "b_rdata", b_rdata, e.exp_b);
            check(e.req, "a_event", 32'(a_event), 32'(e.exp_aevt));
            check(e.req, "b_event", 32'(b_event), 32'(e.exp_bevt));
            check(e.req, "wr_clash", 32'(wr_clash), 32'(e.exp_clash));
        end
    end

    initial begin
        rst = 1'b1;
        a_we = 0; a_addr = '0; a_wdata = '0;
        b_we = 0; b_addr = '0; b_wdata = '0;
        repeat (3) @(negedge clk);
        // R8: outputs quiet during reset
        check("R8", "a_rdata", a_rdata, 0);
        check("R8", "b_rdata", b_rdata, 0);
        check("R8", "events", 32'({a_event, b_event}), 0);
        check("R8", "wr_clash", 32'(wr_clash), 0);
        // Mailbox write attempted during reset must not leak out afterwards.
        b_we = 1; b_addr = 9'h1FE;
        @(negedge clk);
        rst = 1'b0; b_we = 0; b_addr = '0;
        cyc(0,0,0, 0,0,0, 0,0,0,0, 2'b00,2'b00,0, "R8");

        // R1: cross-port readback both directions
        cyc(1,5,32'hAAAA_0005, 1,9'h100,32'hBBBB_0100, 0,0,0,0, 0,0,0, "R1");
        cyc(0,9'h100,0, 0,5,0, 1,32'hBBBB_0100, 1,32'hAAAA_0005, 0,0,0, "R1");

        // R2: back-to-back reads on B, new word every cycle
        cyc(1,10,32'h1111_0010, 0,0,0, 0,0,0,0, 0,0,0, "R2");
        cyc(1,11,32'h1111_0011, 0,0,0, 0,0,0,0, 0,0,0, "R2");
        cyc(0,0,0, 0,10,0, 0,0, 1,32'h1111_0010, 0,0,0, "R2");
        cyc(0,0,0, 0,11,0, 0,0, 1,32'h1111_0011, 0,0,0, "R2");
        cyc(0,0,0, 0,5,0,  0,0, 1,32'hAAAA_0005, 0,0,0, "R2");

        // R3: streaming read on B while A rewrites the same word
        cyc(1,5,32'hCCCC_0005, 0,5,0, 0,0, 1,32'hAAAA_0005, 0,0,0, "R3");
        cyc(0,0,0, 0,5,0, 0,0, 1,32'hCCCC_0005, 0,0,0, "R3");
        cyc(0,5,0, 1,5,32'hDDDD_0005, 1,32'hCCCC_0005, 0,0, 0,0,0, "R3");

        // R4: B writes mailbox words, event on A side only, one cycle
        cyc(0,0,0, 1,9'h1FE,32'h0000_00E1, 0,0,0,0, 2'b01,2'b00,0, "R4");
        cyc(0,0,0, 0,0,0, 0,0,0,0, 2'b00,2'b00,0, "R4");
        cyc(0,0,0, 1,9'h1FF,32'h0000_00E2, 0,0,0,0, 2'b10,2'b00,0, "R4");
        cyc(0,9'h1FF,0, 0,0,0, 1,32'h0000_00E2, 0,0, 2'b00,2'b00,0, "R4");

        // R5: A writes mailbox words, event on B side only
        cyc(1,9'h1FE,32'h0000_00A1, 0,0,0, 0,0,0,0, 2'b00,2'b01,0, "R5");
        cyc(1,9'h1FF,32'h0000_00A2, 0,0,0, 0,0,0,0, 2'b00,2'b10,0, "R5");
        cyc(1,9'h1FE,32'h0000_00A3, 1,9'h1FF,32'h0000_00B3, 0,0,0,0, 2'b10,2'b01,0, "R5");
        cyc(0,0,0, 0,9'h1FE,0, 0,0, 1,32'h0000_00A3, 2'b00,2'b00,0, "R5");

        // R6: top non-mailbox word and mailbox reads raise nothing
        cyc(1,9'h1FD,32'h0000_01FD, 1,9'h000,32'h0000_0000, 0,0,0,0, 2'b00,2'b00,0, "R6");
        cyc(0,9'h1FE,0, 0,9'h1FF,0, 1,32'h0000_00A3, 1,32'h0000_00B3, 2'b00,2'b00,0, "R6");

        // R7: same-address double write, A wins, clash pulse
        cyc(1,9'h020,32'hA0A0_0020, 1,9'h020,32'hB0B0_0020, 0,0,0,0, 0,0,1, "R7");
        cyc(0,9'h020,0, 0,9'h020,0, 1,32'hA0A0_0020, 1,32'hA0A0_0020, 0,0,0, "R7");
        cyc(1,9'h1FF,32'h0000_0AAA, 1,9'h1FF,32'h0000_0BBB, 0,0,0,0, 2'b10,2'b10,1, "R7");
        cyc(0,9'h1FF,0, 0,0,0, 1,32'h0000_0AAA, 0,0, 0,0,0, "R7");

        // R9: distinct-address double write, both land
        cyc(1,9'h030,32'h3030_0030, 1,9'h031,32'h3131_0031, 0,0,0,0, 0,0,0, "R9");
        cyc(0,9'h031,0, 0,9'h030,0, 1,32'h3131_0031, 1,32'h3030_0030, 0,0,0, "R9");

        cyc(0,0,0, 0,0,0, 0,0,0,0, 0,0,0, "R6");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule